// File: doc/BRIEF.md
# Programmable Integer Clock-Enable Divider

This block turns a fast reference clock into a slower rate by an integer factor that software loads through a one-cycle write strobe. It gives two outputs. The first is a strobe that is high for one reference cycle at the start of every output period, for logic that stays on the reference clock. The second is a divided clock level with an almost even duty cycle.

The factor field is five bits wide. Codes 2 through 31 divide by exactly the code value, odd values included. Codes 0 and 1 do not bypass the divider: they stop both outputs completely. A newly written factor waits in a holding register and is adopted only when the running output period ends. The output period therefore never comes out shorter or longer than one of the two factors. Software is expected to load the factor before any downstream consumer starts to use the divided rate.

Top module: `intdiv_clkgen`

## Requirements
- R1: After reset, which is asynchronous and active low, both outputs are low and the active factor is code 0. They stay low, with no write, until a factor is loaded. A reset applied while the divider is running forces both outputs low at once.
- R2: While the active factor code is 0 or 1, `tick_o` and `div_clk_o` stay low for every cycle.
- R3: With an active factor code N from 2 to 31, `tick_o` is high in exactly one of every N consecutive reference cycles. Successive strobes are exactly N cycles apart.
- R4: `tick_o` is never high for two consecutive reference cycles.
- R5: With active factor N, `div_clk_o` is high for floor(N/2) cycles and low for the remaining cycles of each period. Its high phase begins in the same cycle as `tick_o`.
- R6: A factor written in the middle of a period does not change that period. The new factor takes over from the next strobe onward.
- R7: A change on `cfg_factor` while `cfg_we` is low has no effect on the outputs.
- R8: From the idle state, a write sampled at rising edge k makes `tick_o` and `div_clk_o` high in the cycle that follows edge k+1.
- R9: Writing code 0 or 1 while the divider runs lets the current period finish in full. Both outputs are then low from the next period boundary onward.
- R10: When several writes land within one period, only the last write before the period's final cycle takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the factor field |
| cfg_factor | input | FACTOR_W (5) | Division factor code; 0 and 1 stop the outputs |
| tick_o | output | 1 | One-cycle strobe at the start of each output period |
| div_clk_o | output | 1 | Divided clock level, high for floor(N/2) cycles |

## Verification
A write sampled at one rising edge reaches the holding register at that edge. From idle, the first strobe and the rising divided clock appear one edge later, so they are sampled at the second falling edge after the write is driven. Every directed test indexes its samples from that first strobe at falling edges, never at the active edge. It computes the expected strobe and clock level for each index from the factor in force during that period. A write driven at index i lands at the edge after i and is adopted at the boundary that follows. From that rule the bench predicts exactly which index carries the first strobe of the new period, or the first idle cycle. Cases with codes 0 and 1 are watched for a window longer than the largest period.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

   typedef enum logic {
      OUT_REGISTERED = 1'b0,
      OUT_DECODED    = 1'b1
   } out_mode_e;

   localparam int unsigned FACTOR_W_DEFAULT = 5;
   localparam int unsigned MIN_DIV_DEFAULT  = 2;

   function automatic int unsigned max_factor(input int unsigned width);
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/intdiv_cfg.sv
module intdiv_cfg #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] din,
   output logic [W-1:0] pend_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (we) begin
         pend_q <= din;
      end
   end

endmodule

// File: rtl/intdiv_cnt.sv
module intdiv_cnt #(
   parameter int unsigned W       = 5,
   parameter int unsigned MIN_DIV = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend,
   output logic [W-1:0] act_q,
   output logic [W-1:0] cnt_q,
   output logic         run_q,
   output logic [W-1:0] act_d,
   output logic [W-1:0] cnt_d,
   output logic         run_d
);

   localparam logic [W-1:0] MIN_V = W'(MIN_DIV);
   localparam logic [W-1:0] ONE_V = W'(1);

   logic last_c;

   always_comb begin
      run_q  = (act_q >= MIN_V);
      last_c = run_q && (cnt_q == (act_q - ONE_V));
      if (!run_q || last_c) begin
         act_d = pend;
         cnt_d = '0;
      end else begin
         act_d = act_q;
         cnt_d = cnt_q + ONE_V;
      end
      run_d = (act_d >= MIN_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else begin
         act_q <= act_d;
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/intdiv_shape.sv
module intdiv_shape
   import intdiv_pkg::*;
#(
   parameter int unsigned W        = 5,
   parameter out_mode_e   OUT_MODE = OUT_REGISTERED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] act_d,
   input  logic [W-1:0] cnt_d,
   input  logic         run_d,
   input  logic [W-1:0] act_q,
   input  logic [W-1:0] cnt_q,
   input  logic         run_q,
   output logic         tick_o,
   output logic         dclk_o
);

   generate
      if (OUT_MODE == OUT_REGISTERED) begin : g_reg
         logic tick_n, dclk_n;
         always_comb begin
            tick_n = run_d && (cnt_d == '0);
            dclk_n = run_d && (cnt_d < (act_d >> 1));
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tick_o <= 1'b0;
               dclk_o <= 1'b0;
            end else begin
               tick_o <= tick_n;
               dclk_o <= dclk_n;
            end
         end
      end else begin : g_dec
         always_comb begin
            tick_o = run_q && (cnt_q == '0);
            dclk_o = run_q && (cnt_q < (act_q >> 1));
         end
      end
   endgenerate

endmodule

// File: rtl/intdiv_clkgen.sv
module intdiv_clkgen
   import intdiv_pkg::*;
#(
   parameter int unsigned FACTOR_W = FACTOR_W_DEFAULT,
   parameter int unsigned MIN_DIV  = MIN_DIV_DEFAULT,
   parameter out_mode_e   OUT_MODE = OUT_REGISTERED
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [FACTOR_W-1:0] cfg_factor,
   output logic                tick_o,
   output logic                div_clk_o
);

   localparam int unsigned MAX_DIV = max_factor(FACTOR_W);

   generate
      if (FACTOR_W < 2 || FACTOR_W > 16) begin : g_bad_width
         $error("intdiv_clkgen: FACTOR_W must lie in 2..16");
      end
      if (MIN_DIV < 2 || MIN_DIV > MAX_DIV) begin : g_bad_min
         $error("intdiv_clkgen: MIN_DIV must lie in 2..MAX_DIV");
      end
   endgenerate

   logic [FACTOR_W-1:0] pend_q;
   logic [FACTOR_W-1:0] act_q, cnt_q, act_d, cnt_d;
   logic                run_q, run_d;

   intdiv_cfg #(.W(FACTOR_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .din    (cfg_factor),
      .pend_q (pend_q)
   );

   intdiv_cnt #(.W(FACTOR_W), .MIN_DIV(MIN_DIV)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend_q),
      .act_q (act_q),
      .cnt_q (cnt_q),
      .run_q (run_q),
      .act_d (act_d),
      .cnt_d (cnt_d),
      .run_d (run_d)
   );

   intdiv_shape #(.W(FACTOR_W), .OUT_MODE(OUT_MODE)) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_d  (act_d),
      .cnt_d  (cnt_d),
      .run_d  (run_d),
      .act_q  (act_q),
      .cnt_q  (cnt_q),
      .run_q  (run_q),
      .tick_o (tick_o),
      .dclk_o (div_clk_o)
   );

endmodule

// File: rtl/intdiv_chk.sv
module intdiv_chk #(
   parameter int unsigned W       = 5,
   parameter int unsigned MIN_DIV = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         dclk,
   input logic [W-1:0] act,
   input logic [W-1:0] cnt
);

   localparam logic [W-1:0] MIN_V = W'(MIN_DIV);

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);                                            // R4
   AST_TICK_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> dclk);                                             // R5
   AST_RISE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dclk) |-> tick);                                      // R5
   AST_LOW_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (act < MIN_V) |-> (!tick && !dclk));                        // R2
   AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act) && act >= MIN_V) |-> tick);                  // R6
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (act >= MIN_V) |-> (cnt < act));                            // R3

endmodule

bind intdiv_clkgen intdiv_chk #(.W(FACTOR_W), .MIN_DIV(MIN_DIV)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tick  (tick_o),
   .dclk  (div_clk_o),
   .act   (act_q),
   .cnt   (cnt_q)
);

// File: tb/test_intdiv_clkgen.sv
module test_intdiv_clkgen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_factor = 5'd0;
   logic       tick, dclk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   localparam int NVEC = 10;
   localparam int VEC_CODE [NVEC] = '{2, 3, 4, 5, 7, 8, 16, 17, 30, 31};
   localparam int VEC_HIGH [NVEC] = '{1, 1, 2, 2, 3, 4, 8,  8,  15, 15};

   intdiv_clkgen i_intdiv_clkgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_factor (cfg_factor),
      .tick_o     (tick),
      .div_clk_o  (dclk)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input int code);
      cfg_we = 1'b1;
      cfg_factor = code[4:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic go_idle();
      wr(0);
      repeat (40) @(negedge clk);
   endtask

   // leaves the bench at index 0 (first strobe expected for code >= 2)
   task automatic start(input int code);
      go_idle();
      wr(code);
      chk(tick === 1'b0, "R8 no strobe one edge after write", int'(tick), 0);
      @(negedge clk);
      chk(tick === (code >= 2), "R8 strobe two edges after write", int'(tick), int'(code >= 2));
   endtask

   task automatic run_window(input int n, input int len, input string req, output int high);
      int bad = 0;
      high = 0;
      for (int i = 0; i < len; i++) begin
         bit et, ec;
         et = (n >= 2) && (i % n == 0);
         ec = (n >= 2) && ((i % n) < n / 2);
         if (tick !== et || dclk !== ec) bad++;
         high += int'(dclk);
         @(negedge clk);
      end
      chk(bad == 0, req, bad, 0);
   endtask

   initial begin
      wait (cyc >= 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int h;
      int bad;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(tick === 1'b0 && dclk === 1'b0, "R1 during reset", int'(tick) + int'(dclk), 0);
      rst_n = 1'b1;
      cfg_factor = 5'd6;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         if (tick !== 1'b0 || dclk !== 1'b0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R1 idle after reset without write", bad, 0);

      // table of vectors
      for (int v = 0; v < NVEC; v++) begin
         start(VEC_CODE[v]);
         run_window(VEC_CODE[v], 3 * VEC_CODE[v], "R3 R4 R5 table period", h);
         chk(h == 3 * VEC_HIGH[v], "R5 high count", h, 3 * VEC_HIGH[v]);
      end

      // full sweep of codes
      for (int c = 0; c < 32; c++) begin
         start(c);
         if (c < 2) run_window(c, 96, "R2 silent code", h);
         else       run_window(c, 2 * c, "R3 sweep period", h);
      end

      // R6: mid-period write keeps the running period
      start(5);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         bit et, ec;
         cfg_we = 1'b0;
         et = (i == 0) || (i == 5) || (i == 14);
         ec = (i < 2) || (i >= 5 && i < 9) || (i >= 14 && i < 18);
         if (tick !== et || dclk !== ec) bad++;
         if (i == 2) begin cfg_we = 1'b1; cfg_factor = 5'd9; end
         @(negedge clk);
      end
      cfg_we = 1'b0;
      chk(bad == 0, "R6 switch 5->9 at boundary", bad, 0);

      // R10: last write in a period wins
      start(6);
      bad = 0;
      for (int i = 0; i < 22; i++) begin
         bit et, ec;
         cfg_we = 1'b0;
         et = (i == 0) || (i == 6) || (i == 14);
         ec = (i < 3) || (i >= 6 && i < 10) || (i >= 14 && i < 18);
         if (tick !== et || dclk !== ec) bad++;
         if (i == 1) begin cfg_we = 1'b1; cfg_factor = 5'd3; end
         if (i == 3) begin cfg_we = 1'b1; cfg_factor = 5'd8; end
         @(negedge clk);
      end
      cfg_we = 1'b0;
      chk(bad == 0, "R10 last write adopted", bad, 0);

      // R9: stop code lets the period finish
      start(4);
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         bit et, ec;
         cfg_we = 1'b0;
         et = (i == 0);
         ec = (i < 2);
         if (tick !== et || dclk !== ec) bad++;
         if (i == 1) begin cfg_we = 1'b1; cfg_factor = 5'd0; end
         @(negedge clk);
      end
      cfg_we = 1'b0;
      chk(bad == 0, "R9 stop at boundary", bad, 0);

      // R7: factor changes without strobe are ignored
      start(3);
      bad = 0;
      for (int i = 0; i < 12; i++) begin
         if (tick !== (i % 3 == 0) || dclk !== (i % 3 == 0)) bad++;
         if (i == 1) cfg_factor = 5'd10;
         if (i == 5) cfg_factor = 5'd0;
         @(negedge clk);
      end
      chk(bad == 0, "R7 no write strobe", bad, 0);

      // R1: reset while running
      start(7);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(tick === 1'b0 && dclk === 1'b0, "R1 async reset while running",
          int'(tick) + int'(dclk), 0);
      @(negedge clk);
      rst_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         if (tick !== 1'b0 || dclk !== 1'b0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R1 idle after reset mid-run", bad, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule